// File: doc/BRIEF.md
# Flash Block Protection Controller

This block sits in front of a small non-volatile memory array, modelled here as a synthesizable register array of 32-bit words. It takes four kinds of requests: instruction fetch, data read, word program and sector erase. Erase clears one 1 KB sector. Protection is kept at twice that size, one setting per 2 KB region. Before it acts on a request, the controller looks up the setting of the addressed region. It then either carries the request out or refuses it with an error flag on the response.

Requests use a valid/ready handshake. A separate configuration port raises the protection of a region, one region per write. A region starts out open. It can be made read-only, which blocks program and erase. It can be made execute-only, which also refuses every data read and every debug-port access and leaves only ordinary instruction fetch. A setting can only become stricter until the next reset. With the default parameters the array holds four regions, which is 8 KB. Setting `NUM_REGIONS` to 64 gives the full 128 KB byte-addressed array, with the region index in address bits [16:11] and the sector index in bits [16:10]. `ERASE_CYCLES` must be at least the number of words in a sector.

Top module: `flash_guard`

## Requirements
- R1: `cmd_ready` is low exactly while `busy` is high, and a command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both high. Every accepted fetch, read or program, and every rejected request, returns `rsp_valid` for one cycle, in the cycle after acceptance.
- R2: An erase accepted for an open region sets every word of the 1 KB sector selected by `cmd_addr[ADDR_W-1:10]` to 0xFFFFFFFF. The other sector of the same region keeps its contents.
- R3: An accepted erase holds `busy` high for exactly `ERASE_CYCLES` cycles, starting in the cycle after acceptance. It then returns `rsp_valid` with `rsp_err` = 0 in the first cycle that `busy` is low.
- R4: A program (`cmd_op` = 2) to an open region replaces the addressed word with the old word AND `cmd_wdata`, so a program can only clear bits.
- R5: A data read (`cmd_op` = 1) or an instruction fetch (`cmd_op` = 0) that is allowed returns the word at `cmd_addr[ADDR_W-1:2]` on `rsp_rdata`, with `rsp_err` = 0. Address bits [1:0] are ignored.
- R6: A region in read-only mode (code 1) rejects program and erase with `rsp_err` = 1 and leaves its contents unchanged. It still serves reads and fetches.
- R7: A region in execute-only mode (code 2) rejects program and erase with `rsp_err` = 1 and leaves its contents unchanged.
- R8: A region in execute-only mode serves only fetches that have `cmd_debug` = 0. A data read, and any request with `cmd_debug` = 1, is refused with `rsp_err` = 1.
- R9: A rejected request never raises `busy` and returns `rsp_rdata` = 0, so refused reads expose no stored data.
- R10: A configuration write (`cfg_we`) takes effect only when `cfg_mode` is numerically above the region's current mode, in the order open = 0, read-only = 1, execute-only = 2. A write of an equal, lower or unused (3) code is ignored.
- R11: The region index is `cmd_addr[ADDR_W-1:11]`, so both 1 KB sectors of a region share one setting. A setting on one region has no effect on any other region.
- R12: After reset every region is open, `busy` and `rsp_valid` are low, and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 0 fetch, 1 read, 2 program, 3 erase |
| cmd_debug | input | 1 | Request comes from a debug port |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 32 | Program data (AND mask) |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access violation for this response |
| rsp_rdata | output | 32 | Read or fetch data, zero otherwise |
| busy | output | 1 | Sector erase in progress |
| cfg_we | input | 1 | Protection configuration write |
| cfg_region | input | RIDX_W | Region to configure |
| cfg_mode | input | 2 | Requested protection code |

## Verification
The main function, the protection check, is tried with every request kind against each of the three modes. Pairs such as a plain read and a debug fetch to an execute-only region show that the debug qualifier is decoded apart from the operation code. Programs with masks that would set bits if the data were written directly tell AND-programming apart from plain overwrite. An erase of one sector followed by reads of its sibling sector tells erase scope apart from protection scope. Downgrades, same-level writes and the unused code are applied between accesses, and a later access shows whether the mode moved.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_FETCH = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_ERASE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        MODE_OPEN   = 2'd0,
        MODE_RDONLY = 2'd1,
        MODE_EXEC   = 2'd2
    } mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ERASE = 1'b1
    } state_e;

    typedef struct packed {
        op_e  op;
        logic dbg;
    } req_t;

    // Decide whether a request may proceed under a region mode.
    function automatic logic permit(req_t r, mode_e m);
        case (m)
            MODE_OPEN:   return 1'b1;
            MODE_RDONLY: return (r.op == OP_FETCH) || (r.op == OP_READ);
            MODE_EXEC:   return (r.op == OP_FETCH) && !r.dbg;
            default:     return 1'b0;
        endcase
    endfunction

    // Only a legal code that is strictly stricter may replace the mode.
    function automatic logic tightens(logic [1:0] req_code, mode_e cur);
        return (req_code <= 2'd2) && (req_code > 2'(cur));
    endfunction

endpackage

// File: rtl/flash_guard_prot.sv
module flash_guard_prot
    import flash_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int RIDX_W      = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [RIDX_W-1:0]        cfg_region,
    input  logic [1:0]               cfg_mode,
    input  logic [RIDX_W-1:0]        rd_region,
    output mode_e                    rd_mode,
    output logic [2*NUM_REGIONS-1:0] mode_flat
);

    mode_e mode_q [NUM_REGIONS];

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[i] <= MODE_OPEN;
            end else if (cfg_we && (cfg_region == RIDX_W'(i))
                         && tightens(cfg_mode, mode_q[i])) begin
                mode_q[i] <= mode_e'(cfg_mode);
            end
        end
        assign mode_flat[2*i +: 2] = 2'(mode_q[i]);
    end

    assign rd_mode = mode_q[rd_region];

endmodule

// File: rtl/flash_guard_check.sv
module flash_guard_check
    import flash_guard_pkg::*;
(
    input  req_t  req,
    input  mode_e mode,
    output logic  allow
);

    always_comb begin
        allow = permit(req, mode);
    end

endmodule

// File: rtl/flash_guard_array.sv
module flash_guard_array
    import flash_guard_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic              and_mode,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    // Storage is non-volatile in the modelled part, so it has no reset.
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= and_mode ? (mem[waddr] & wdata) : wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int NUM_REGIONS        = 4,
    parameter int SECTORS_PER_REGION = 2,
    parameter int SECTOR_BYTES       = 1024,
    parameter int ERASE_CYCLES       = 300,
    parameter int ADDR_W = $clog2(NUM_REGIONS * SECTORS_PER_REGION * SECTOR_BYTES),
    parameter int RIDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_debug,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [31:0]       cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              busy,
    input  logic              cfg_we,
    input  logic [RIDX_W-1:0] cfg_region,
    input  logic [1:0]        cfg_mode
);

    localparam int SECTOR_WORDS = SECTOR_BYTES / 4;
    localparam int SW_AW        = $clog2(SECTOR_WORDS);
    localparam int SEC_LSB      = $clog2(SECTOR_BYTES);
    localparam int REG_LSB      = $clog2(SECTOR_BYTES * SECTORS_PER_REGION);
    localparam int SIDX_W       = ADDR_W - SEC_LSB;
    localparam int WORD_AW      = ADDR_W - 2;
    localparam int DEPTH        = 1 << WORD_AW;
    localparam int CNT_W        = $clog2(ERASE_CYCLES + 1);

    state_e              state;
    logic [CNT_W-1:0]    er_cnt;
    logic [SIDX_W-1:0]   er_sector;
    logic                accept;
    logic                allow;
    req_t                req;
    mode_e               cur_mode;
    logic [2*NUM_REGIONS-1:0] mode_flat;
    logic [RIDX_W-1:0]   req_region;
    logic [WORD_AW-1:0]  req_word;
    logic [SIDX_W-1:0]   req_sector;
    logic                unused_lsb;

    logic                arr_we;
    logic                arr_and;
    logic [WORD_AW-1:0]  arr_waddr;
    logic [WORD_W-1:0]   arr_wdata;
    logic [WORD_W-1:0]   arr_rdata;

    assign req_region = cmd_addr[ADDR_W-1:REG_LSB];
    assign req_word   = cmd_addr[ADDR_W-1:2];
    assign req_sector = cmd_addr[ADDR_W-1:SEC_LSB];
    assign unused_lsb = ^cmd_addr[1:0];
    assign req.op     = op_e'(cmd_op);
    assign req.dbg    = cmd_debug;

    assign cmd_ready = (state == ST_IDLE);
    assign busy      = (state == ST_ERASE);
    assign accept    = cmd_valid && cmd_ready;

    flash_guard_prot #(
        .NUM_REGIONS(NUM_REGIONS),
        .RIDX_W     (RIDX_W)
    ) u_prot (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_region(cfg_region),
        .cfg_mode  (cfg_mode),
        .rd_region (req_region),
        .rd_mode   (cur_mode),
        .mode_flat (mode_flat)
    );

    flash_guard_check u_check (
        .req  (req),
        .mode (cur_mode),
        .allow(allow)
    );

    flash_guard_array #(
        .DEPTH(DEPTH),
        .AW   (WORD_AW)
    ) u_array (
        .clk     (clk),
        .we      (arr_we),
        .and_mode(arr_and),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr   (req_word),
        .rdata   (arr_rdata)
    );

    // Write port: the erase sweep owns it while busy, a program otherwise.
    always_comb begin
        arr_we    = 1'b0;
        arr_and   = 1'b0;
        arr_waddr = req_word;
        arr_wdata = cmd_wdata;
        if (state == ST_ERASE) begin
            if (er_cnt < CNT_W'(SECTOR_WORDS)) begin
                arr_we    = 1'b1;
                arr_waddr = {er_sector, er_cnt[SW_AW-1:0]};
                arr_wdata = '1;
            end
        end else if (accept && (req.op == OP_PROG) && allow) begin
            arr_we  = 1'b1;
            arr_and = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            er_cnt    <= '0;
            er_sector <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if ((req.op == OP_ERASE) && allow) begin
                            state     <= ST_ERASE;
                            er_cnt    <= '0;
                            er_sector <= req_sector;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_err   <= !allow;
                            rsp_rdata <= (allow && ((req.op == OP_READ) || (req.op == OP_FETCH)))
                                         ? arr_rdata : '0;
                        end
                    end
                end
                ST_ERASE: begin
                    er_cnt <= er_cnt + 1'b1;
                    if (er_cnt == CNT_W'(ERASE_CYCLES - 1)) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b0;
                        rsp_rdata <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk #(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 13,
    parameter int REG_LSB     = 11
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic                     cmd_ready,
    input logic [1:0]               cmd_op,
    input logic                     cmd_debug,
    input logic [ADDR_W-1:0]        cmd_addr,
    input logic                     busy,
    input logic                     rsp_valid,
    input logic                     rsp_err,
    input logic [31:0]              rsp_rdata,
    input logic [2*NUM_REGIONS-1:0] mode_flat
);

    logic       acc;
    logic [1:0] cur_mode;
    logic       unused_chk;

    assign acc        = cmd_valid && cmd_ready;
    assign unused_chk = ^cmd_addr[REG_LSB-1:0];

    always_comb begin
        cur_mode = mode_flat[2*int'(cmd_addr[ADDR_W-1:REG_LSB]) +: 2];
    end

    AST_QUICK_RSP: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op != 2'd3) |=> rsp_valid); // R1

    AST_BUSY_FROM_ERASE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(acc && cmd_op == 2'd3)); // R3

    AST_ERASE_DONE_RSP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (rsp_valid && !rsp_err)); // R3

    AST_LOCKED_WRITE_REJ: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op[1] && cur_mode != 2'd0) |=> (rsp_valid && rsp_err && !busy)); // R6

    AST_EXEC_READ_REJ: assert property (@(posedge clk) disable iff (rst)
        (acc && cur_mode == 2'd2 && (cmd_op == 2'd1 || cmd_debug)) |=> rsp_err); // R8

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0)); // R9

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_mono
        AST_MODE_NO_RELAX: assert property (@(posedge clk) disable iff (rst)
            mode_flat[2*i +: 2] >= $past(mode_flat[2*i +: 2])); // R10
    end

endmodule

bind flash_guard flash_guard_chk #(
    .NUM_REGIONS(NUM_REGIONS),
    .ADDR_W     (ADDR_W),
    .REG_LSB    (REG_LSB)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_op   (cmd_op),
    .cmd_debug(cmd_debug),
    .cmd_addr (cmd_addr),
    .busy     (busy),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .mode_flat(mode_flat)
);

// File: tb/tb_flash_guard.sv
module tb_flash_guard;

    localparam int CLK_PERIOD   = 10;
    localparam int ERASE_CYCLES = 300;
    localparam int ADDR_W       = 13;
    localparam int RIDX_W       = 2;
    localparam int NSECT        = 8;

    // kind: 0 fetch, 1 read, 2 program, 3 erase, 4 protection write
    // (for kind 4 the addr field holds the region and wdata[1:0] the code)
    typedef struct packed {
        logic [2:0]  kind;
        logic        dbg;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        exp_err;
        logic [31:0] exp_data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t TABLE [NV] = '{
        '{3'd1, 1'b0, 16'h0000, 32'h0,        1'b0, 32'hFFFFFFFF, 8'd2},  // R2 erased word
        '{3'd2, 1'b0, 16'h0000, 32'h12345678, 1'b0, 32'h0,        8'd4},  // R4
        '{3'd1, 1'b0, 16'h0003, 32'h0,        1'b0, 32'h12345678, 8'd5},  // R5 low bits ignored
        '{3'd2, 1'b0, 16'h0000, 32'hFF00FFFF, 1'b0, 32'h0,        8'd4},  // R4
        '{3'd1, 1'b0, 16'h0000, 32'h0,        1'b0, 32'h12005678, 8'd4},  // R4 AND result
        '{3'd2, 1'b0, 16'h0404, 32'hA5A5A5A5, 1'b0, 32'h0,        8'd4},  // R4
        '{3'd0, 1'b0, 16'h0404, 32'h0,        1'b0, 32'hA5A5A5A5, 8'd5},  // R5 fetch
        '{3'd2, 1'b0, 16'h0800, 32'h00001111, 1'b0, 32'h0,        8'd4},  // R4
        '{3'd2, 1'b0, 16'h1000, 32'hCAFEBABE, 1'b0, 32'h0,        8'd4},  // R4
        '{3'd2, 1'b0, 16'h1800, 32'h0BADF00D, 1'b0, 32'h0,        8'd4},  // R4
        '{3'd4, 1'b0, 16'd1,    32'd1,        1'b0, 32'h0,        8'd10}, // R10 region1 read-only
        '{3'd2, 1'b0, 16'h0800, 32'h0,        1'b1, 32'h0,        8'd6},  // R6
        '{3'd1, 1'b0, 16'h0800, 32'h0,        1'b0, 32'h00001111, 8'd6},  // R6 unchanged
        '{3'd3, 1'b0, 16'h0C00, 32'h0,        1'b1, 32'h0,        8'd6},  // R6 erase refused
        '{3'd1, 1'b0, 16'h0C00, 32'h0,        1'b0, 32'hFFFFFFFF, 8'd6},  // R6
        '{3'd4, 1'b0, 16'd2,    32'd2,        1'b0, 32'h0,        8'd10}, // R10 region2 execute-only
        '{3'd1, 1'b0, 16'h1000, 32'h0,        1'b1, 32'h0,        8'd8},  // R8 data read
        '{3'd1, 1'b1, 16'h1000, 32'h0,        1'b1, 32'h0,        8'd8},  // R8 debug read
        '{3'd0, 1'b1, 16'h1000, 32'h0,        1'b1, 32'h0,        8'd8},  // R8 debug fetch
        '{3'd0, 1'b0, 16'h1000, 32'h0,        1'b0, 32'hCAFEBABE, 8'd8},  // R8 fetch allowed
        '{3'd2, 1'b0, 16'h1000, 32'h0,        1'b1, 32'h0,        8'd7},  // R7
        '{3'd3, 1'b0, 16'h1400, 32'h0,        1'b1, 32'h0,        8'd7},  // R7
        '{3'd0, 1'b0, 16'h1000, 32'h0,        1'b0, 32'hCAFEBABE, 8'd7},  // R7 unchanged
        '{3'd4, 1'b0, 16'd2,    32'd0,        1'b0, 32'h0,        8'd10}, // R10 downgrade
        '{3'd1, 1'b0, 16'h1000, 32'h0,        1'b1, 32'h0,        8'd10}, // R10 still execute-only
        '{3'd4, 1'b0, 16'd1,    32'd2,        1'b0, 32'h0,        8'd10}, // R10 upgrade
        '{3'd1, 1'b0, 16'h0800, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
        '{3'd0, 1'b0, 16'h0800, 32'h0,        1'b0, 32'h00001111, 8'd10}, // R10
        '{3'd4, 1'b0, 16'd1,    32'd1,        1'b0, 32'h0,        8'd10}, // R10 downgrade
        '{3'd1, 1'b0, 16'h0800, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
        '{3'd4, 1'b0, 16'd3,    32'd3,        1'b0, 32'h0,        8'd10}, // R10 unused code
        '{3'd2, 1'b0, 16'h1800, 32'hFFFF0000, 1'b0, 32'h0,        8'd11}, // R11 region3 open
        '{3'd1, 1'b0, 16'h1800, 32'h0,        1'b0, 32'h0BAD0000, 8'd11}, // R11
        '{3'd1, 1'b0, 16'h0404, 32'h0,        1'b0, 32'hA5A5A5A5, 8'd11}, // R11 region0 open
        '{3'd3, 1'b0, 16'h0000, 32'h0,        1'b0, 32'h0,        8'd2},  // R2 erase sector0
        '{3'd1, 1'b0, 16'h0000, 32'h0,        1'b0, 32'hFFFFFFFF, 8'd2},  // R2
        '{3'd1, 1'b0, 16'h0404, 32'h0,        1'b0, 32'hA5A5A5A5, 8'd2}   // R2 sibling kept
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [1:0]        cmd_op = 2'd0;
    logic              cmd_debug = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [31:0]       cmd_wdata = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [31:0]       rsp_rdata;
    logic              busy;
    logic              cfg_we = 1'b0;
    logic [RIDX_W-1:0] cfg_region = '0;
    logic [1:0]        cfg_mode = 2'd0;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard #(.ERASE_CYCLES(ERASE_CYCLES)) dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_debug(cmd_debug), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .busy(busy), .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_mode(cfg_mode)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Issue one command; returns error flag, data and response latency in cycles.
    task automatic run_cmd(input logic [1:0] op, input logic dbg,
                           input logic [ADDR_W-1:0] addr, input logic [31:0] wd,
                           output logic err, output logic [31:0] data, output int lat);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_debug = dbg; cmd_addr = addr; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < ERASE_CYCLES + 10) begin
            @(negedge clk);
            lat++;
        end
        err  = rsp_err;
        data = rsp_rdata;
    endtask

    task automatic set_mode(input logic [RIDX_W-1:0] r, input logic [1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = r; cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic        err;
        logic [31:0] data;
        int          lat;
        int          bcnt;
        logic        rdy_seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check(busy == 1'b0, "R12", "busy after reset", 32'(busy), 32'd0);
        check(rsp_valid == 1'b0, "R12", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check(cmd_ready == 1'b1, "R12", "cmd_ready after reset", 32'(cmd_ready), 32'd1);

        // R3 / R1: first erase, counted cycle by cycle
        @(negedge clk);
        cmd_op = 2'd3; cmd_debug = 1'b0; cmd_addr = '0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bcnt = 0;
        rdy_seen = 1'b0;
        while (busy && bcnt < ERASE_CYCLES + 10) begin
            if (cmd_ready) rdy_seen = 1'b1;
            if (rsp_valid) rdy_seen = 1'b1;
            bcnt++;
            @(negedge clk);
        end
        check(bcnt == ERASE_CYCLES, "R3", "busy cycles", 32'(bcnt), 32'(ERASE_CYCLES));
        check(!rdy_seen, "R1", "ready or response while busy", 32'(rdy_seen), 32'd0);
        check(rsp_valid && !rsp_err, "R3", "erase completion response",
              {30'd0, rsp_valid, rsp_err}, 32'd2);

        // Remaining sectors start erased; R2 initial fill
        for (int s = 1; s < NSECT; s++) begin
            run_cmd(2'd3, 1'b0, ADDR_W'(s * 1024), 32'h0, err, data, lat);
            check(!err && lat == ERASE_CYCLES + 1, "R2", "initial erase",
                  32'(lat), 32'(ERASE_CYCLES + 1));
        end

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", TABLE[i].req);
            if (TABLE[i].kind == 3'd4) begin
                set_mode(RIDX_W'(TABLE[i].addr), TABLE[i].wdata[1:0]);
            end else begin
                run_cmd(TABLE[i].kind[1:0], TABLE[i].dbg, TABLE[i].addr[ADDR_W-1:0],
                        TABLE[i].wdata, err, data, lat);
                check(err == TABLE[i].exp_err, tag, $sformatf("vector %0d err", i),
                      32'(err), 32'(TABLE[i].exp_err));
                check(data == TABLE[i].exp_data, tag, $sformatf("vector %0d data", i),
                      data, TABLE[i].exp_data);
                if (TABLE[i].kind == 3'd3 && !TABLE[i].exp_err) begin
                    check(lat == ERASE_CYCLES + 1, "R3", $sformatf("vector %0d latency", i),
                          32'(lat), 32'(ERASE_CYCLES + 1));
                end else begin
                    check(lat == 1, TABLE[i].exp_err ? "R9" : "R1",
                          $sformatf("vector %0d latency", i), 32'(lat), 32'd1);
                end
                if (TABLE[i].exp_err) begin
                    check(!busy, "R9", $sformatf("vector %0d busy after reject", i),
                          32'(busy), 32'd0);
                end
            end
        end

        // R12: reset returns every region to open
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run_cmd(2'd1, 1'b0, ADDR_W'(16'h1000), 32'h0, err, data, lat);
        check(!err && data == 32'hCAFEBABE, "R12", "read after reset reopens region",
              data, 32'hCAFEBABE);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule